// File: doc/BRIEF.md
# Merging Write Buffer with Read Bypass

This block sits between a write-back cache and main memory. It holds up to four pending block writes, both stores and dirty evictions. Each entry carries a block address, a line of data words and one valid bit per word. A write whose block address is already held in an entry that is not being drained is folded into that entry: only its masked words change, and their valid bits are set. Otherwise the write takes a free entry. When no entry is free and nothing can merge, the writer is stalled. Entries drain to memory one at a time, oldest first, over a shared memory port.

A read miss is checked against every held entry in the same cycle. If no entry matches, the read goes out on the memory port at once, ahead of all queued writes, and the drain pauses. If an entry matches, the buffer returns the held words and their valid bits directly. No memory read is issued, and the drain goes on. The cache handles a read miss that evicts a dirty line by writing the victim into the buffer first and then issuing the read. The read then reaches memory before the victim does, so the read never waits for the buffer to empty.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `mem_req_o`, `wr_stall_o` and `rd_match_o` are 0.
- R2: `wr_stall_o` is 1 only when all entries are occupied and the write address matches no mergeable entry. A stalled write has no effect: a later read of its address finds no match.
- R3: A write to a block address held in a mergeable entry updates only the words whose `wr_mask_i` bit is set. Word w sits at bits [w*DW +: DW]. The write ORs its mask into that entry's valid bits, uses no new entry and is not stalled, even when the buffer is full.
- R4: With no read pending, the oldest entry is presented as a memory write (`mem_we_o`=1) with its address, data and valid mask. It is removed on the cycle `mem_gnt_i` is 1, and entries leave in arrival order.
- R5: A read request matching no entry drives a memory read (`mem_we_o`=0, `mem_addr_o`=`rd_addr_i`) in the same cycle, ahead of any queued write. `rd_gnt_o` follows `mem_gnt_i` for that read.
- R6: A read request matching one or more entries sets `rd_match_o`, issues no memory read and leaves the drain running. For each word it returns the data of the youngest matching entry that holds that word, and `rd_mask_o` is the OR of their valid bits.
- R7: The oldest entry stops accepting merges once its drain write has been presented. A later write to that address takes a new entry, or stalls if the buffer is full.
- R8: A drain write that a read pre-empts or that waits for grant comes back with the same address, data and mask until it is granted.
- R9: A dirty victim written in one cycle, followed by a read miss to another block, gives the read the memory port first. The victim drains after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write offered; taken when `wr_stall_o` is 0 |
| wr_addr_i | input | AW | Block address of the write |
| wr_mask_i | input | WORDS | Words carried by the write |
| wr_data_i | input | WORDS*DW | Write data, word w at [w*DW +: DW] |
| wr_stall_o | output | 1 | Write cannot be taken this cycle |
| rd_req_i | input | 1 | Read miss to check |
| rd_addr_i | input | AW | Block address of the read miss |
| rd_match_o | output | 1 | Read address is held in the buffer |
| rd_mask_o | output | WORDS | Words held for the read address |
| rd_data_o | output | WORDS*DW | Held data for the read address |
| rd_gnt_o | output | 1 | Bypassing read accepted by memory |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = drain write, 0 = read |
| mem_addr_o | output | AW | Memory block address |
| mem_mask_o | output | WORDS | Word enables of a drain write |
| mem_data_o | output | WORDS*DW | Drain write data |
| mem_gnt_i | input | 1 | Memory takes the current request |

## Verification
The read check, the stall flag and the choice of memory request are combinational, so they are due in the same cycle as the stimulus. Merges, new entries and removals show up only after the next rising edge. The bench changes inputs on the falling edge and samples combinational results 1 ns later, well before the next rising edge. It looks for state effects one full cycle later, through a read check or the next drain write. Drain order and merged contents are worked out in the bench from the addresses, masks and words it drove.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic {
    MEM_OP_RD = 1'b0,
    MEM_OP_WR = 1'b1
  } mem_op_e;
endpackage

// File: rtl/wbuf_addr_match.sv
module wbuf_addr_match #(
  parameter int DEPTH = 4,
  parameter int AW    = 8
) (
  input  logic [AW-1:0]             addr_i,
  input  logic [DEPTH-1:0][AW-1:0]  tag_i,
  input  logic [DEPTH-1:0]          occ_i,
  output logic [DEPTH-1:0]          hit_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_o[i] = occ_i[i] && (tag_i[i] == addr_i);
  end
endmodule

// File: rtl/wbuf_read_view.sv
module wbuf_read_view #(
  parameter int DEPTH = 4,
  parameter int WORDS = 4,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int BW   = WORDS * DW
) (
  input  logic [PW-1:0]               head_i,
  input  logic [DEPTH-1:0]            hit_i,
  input  logic [DEPTH-1:0][BW-1:0]    data_i,
  input  logic [DEPTH-1:0][WORDS-1:0] mask_i,
  output logic [BW-1:0]               data_o,
  output logic [WORDS-1:0]            mask_o
);
  logic [PW-1:0] idx;

  // walk oldest to youngest so younger words override
  always_comb begin
    data_o = '0;
    mask_o = '0;
    idx    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_i + PW'(k);
      if (hit_i[idx]) begin
        mask_o = mask_o | mask_i[idx];
        for (int w = 0; w < WORDS; w++) begin
          if (mask_i[idx][w]) data_o[w*DW +: DW] = data_i[idx][w*DW +: DW];
        end
      end
    end
  end
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int WORDS = 4,
  parameter int DW    = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_valid_i,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic [WORDS-1:0]      wr_mask_i,
  input  logic [WORDS*DW-1:0]   wr_data_i,
  output logic                  wr_stall_o,
  input  logic                  rd_req_i,
  input  logic [AW-1:0]         rd_addr_i,
  output logic                  rd_match_o,
  output logic [WORDS-1:0]      rd_mask_o,
  output logic [WORDS*DW-1:0]   rd_data_o,
  output logic                  rd_gnt_o,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [AW-1:0]         mem_addr_o,
  output logic [WORDS-1:0]      mem_mask_o,
  output logic [WORDS*DW-1:0]   mem_data_o,
  input  logic                  mem_gnt_i
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = WORDS * DW;

  logic [DEPTH-1:0][AW-1:0]    addr_q;
  logic [DEPTH-1:0][BW-1:0]    data_q;
  logic [DEPTH-1:0][WORDS-1:0] mask_q;
  logic [PW-1:0]               head_q;
  logic [CW-1:0]               count_q;
  logic                        lock_q;

  logic [DEPTH-1:0] occ, wr_hit, rd_hit, merge_ok, head_oh;
  logic [PW-1:0]    merge_idx, tail;
  logic             empty, full, merge_any, push, merge, pop;
  logic             rd_bypass, wr_present, drain_busy;
  mem_op_e          op;

  for (genvar i = 0; i < DEPTH; i++) begin : g_occ
    logic [PW-1:0] age;
    assign age    = PW'(i) - head_q;
    assign occ[i] = CW'(age) < count_q;
  end

  wbuf_addr_match #(.DEPTH(DEPTH), .AW(AW)) u_wr_match (
    .addr_i(wr_addr_i), .tag_i(addr_q), .occ_i(occ), .hit_o(wr_hit)
  );

  wbuf_addr_match #(.DEPTH(DEPTH), .AW(AW)) u_rd_match (
    .addr_i(rd_addr_i), .tag_i(addr_q), .occ_i(occ), .hit_o(rd_hit)
  );

  wbuf_read_view #(.DEPTH(DEPTH), .WORDS(WORDS), .DW(DW)) u_view (
    .head_i(head_q), .hit_i(rd_hit), .data_i(data_q), .mask_i(mask_q),
    .data_o(rd_data_o), .mask_o(rd_mask_o)
  );

  assign empty      = (count_q == '0);
  assign full       = (count_q == CW'(DEPTH));
  assign rd_match_o = rd_req_i && (|rd_hit);
  assign rd_bypass  = rd_req_i && !(|rd_hit);
  assign wr_present = !empty && !rd_bypass;
  // head is frozen from its first presentation until granted
  assign drain_busy = lock_q || wr_present;
  assign head_oh    = DEPTH'(1) << head_q;
  assign merge_ok   = wr_hit & ~(drain_busy ? head_oh : '0);
  assign merge_any  = |merge_ok;

  always_comb begin
    merge_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (merge_ok[i]) merge_idx = PW'(i);
    end
  end

  assign wr_stall_o = full && !merge_any;
  assign merge      = wr_valid_i && merge_any;
  assign push       = wr_valid_i && !merge_any && !full;
  assign tail       = head_q + PW'(count_q);

  assign op         = rd_bypass ? MEM_OP_RD : MEM_OP_WR;
  assign mem_req_o  = rd_bypass || !empty;
  assign mem_we_o   = (op == MEM_OP_WR);
  assign mem_addr_o = rd_bypass ? rd_addr_i : addr_q[head_q];
  assign mem_mask_o = rd_bypass ? '0 : mask_q[head_q];
  assign mem_data_o = rd_bypass ? '0 : data_q[head_q];
  assign rd_gnt_o   = rd_bypass && mem_gnt_i;
  assign pop        = wr_present && mem_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      data_q  <= '0;
      mask_q  <= '0;
      head_q  <= '0;
      count_q <= '0;
      lock_q  <= 1'b0;
    end else begin
      if (push) begin
        addr_q[tail] <= wr_addr_i;
        mask_q[tail] <= wr_mask_i;
        data_q[tail] <= wr_data_i;
      end
      if (merge) begin
        mask_q[merge_idx] <= mask_q[merge_idx] | wr_mask_i;
        for (int w = 0; w < WORDS; w++) begin
          if (wr_mask_i[w]) data_q[merge_idx][w*DW +: DW] <= wr_data_i[w*DW +: DW];
        end
      end
      if (pop) head_q <= head_q + PW'(1);
      count_q <= count_q + CW'(push) - CW'(pop);
      lock_q  <= pop ? 1'b0 : (lock_q || wr_present);
    end
  end
endmodule

// File: rtl/merge_wbuf_chk.sv
module merge_wbuf_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int WORDS = 4,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_stall_o,
  input logic                rd_req_i,
  input logic                rd_match_o,
  input logic                mem_req_o,
  input logic                mem_we_o,
  input logic [AW-1:0]       mem_addr_o,
  input logic [WORDS-1:0]    mem_mask_o,
  input logic [WORDS*DW-1:0] mem_data_o,
  input logic                mem_gnt_i,
  input logic [CW-1:0]       count_q,
  input logic                lock_q
);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == '0 && !rd_req_i) |-> !mem_req_o);

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));

  p_stall_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stall_o |-> (count_q == CW'(DEPTH)));

  p_bypass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !rd_match_o) |-> (mem_req_o && !mem_we_o));

  p_match_no_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_match_o |-> (rd_req_i && (!mem_req_o || mem_we_o)));

  p_lock_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |-> (count_q != '0));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mem_req_o && mem_we_o && !mem_gnt_i) && mem_req_o && mem_we_o)
      |-> ($stable(mem_addr_o) && $stable(mem_data_o) && $stable(mem_mask_o)));
endmodule

bind merge_wbuf merge_wbuf_chk #(.DEPTH(DEPTH), .AW(AW), .WORDS(WORDS), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_stall_o(wr_stall_o), .rd_req_i(rd_req_i),
  .rd_match_o(rd_match_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_mask_o(mem_mask_o), .mem_data_o(mem_data_o),
  .mem_gnt_i(mem_gnt_i), .count_q(count_q), .lock_q(lock_q)
);

// File: tb/merge_wbuf_test.sv
`timescale 1ns/1ps
module merge_wbuf_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [3:0]  wr_mask = '0;
  logic [31:0] wr_data = '0;
  logic        wr_stall;
  logic        rd_req = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic        rd_match;
  logic [3:0]  rd_mask;
  logic [31:0] rd_data;
  logic        rd_gnt;
  logic        mem_req, mem_we;
  logic [7:0]  mem_addr;
  logic [3:0]  mem_mask;
  logic [31:0] mem_data;
  logic        mem_gnt = 1'b0;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  merge_wbuf uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_mask_i(wr_mask), .wr_data_i(wr_data),
    .wr_stall_o(wr_stall),
    .rd_req_i(rd_req), .rd_addr_i(rd_addr), .rd_match_o(rd_match), .rd_mask_o(rd_mask),
    .rd_data_o(rd_data), .rd_gnt_o(rd_gnt),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_mask_o(mem_mask),
    .mem_data_o(mem_data), .mem_gnt_i(mem_gnt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // word w of a masked line: address mixed with word index, zero where unmasked
  function automatic logic [31:0] mk(input logic [7:0] a, input logic [3:0] m);
    logic [31:0] r = '0;
    for (int w = 0; w < 4; w++) if (m[w]) r[w*8 +: 8] = a ^ 8'(8'h50 + w);
    return r;
  endfunction

  task automatic do_wr(input logic [7:0] a, input logic [3:0] m, input logic [31:0] d,
                       input logic exp_stall, input string tag);
    wr_valid = 1'b1; wr_addr = a; wr_mask = m; wr_data = d;
    #1 chk(tag, 32'(wr_stall), 32'(exp_stall));
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, input logic exp_match, input logic [3:0] exp_mask,
                       input logic [31:0] exp_data, input string tag);
    rd_req = 1'b1; rd_addr = a;
    #1 chk(tag, 32'(rd_match), 32'(exp_match));
    if (exp_match) begin
      chk(tag, 32'(rd_mask), 32'(exp_mask));
      chk(tag, rd_data, exp_data);
      chk(tag, 32'(mem_req && !mem_we), 32'(0));
    end else begin
      chk(tag, 32'(mem_req && !mem_we && mem_addr == a), 32'(1));
    end
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_drain(input logic [7:0] a, input logic [3:0] m, input logic [31:0] d,
                          input string tag);
    mem_gnt = 1'b1;
    #1 chk(tag, 32'(mem_req && mem_we), 32'(1));
    chk(tag, 32'(mem_addr), 32'(a));
    chk(tag, 32'(mem_mask), 32'(m));
    chk(tag, mem_data, d);
    @(negedge clk);
    mem_gnt = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] line12;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 stall", 32'(wr_stall), 0);
    chk("R1 match", 32'(rd_match), 0);
    @(negedge clk);

    // fill: stall must stay low until the last entry is taken
    for (int i = 0; i < 4; i++)
      do_wr(8'(8'h10 + i), 4'(1 << i), mk(8'(8'h10 + i), 4'(1 << i)), 1'b0, "R2 fill");
    #1 chk("R4 head presented", 32'(mem_addr), 32'h10);
    @(negedge clk);

    do_wr(8'h20, 4'hF, mk(8'h20, 4'hF), 1'b1, "R2 full new addr");
    do_rd(8'h20, 1'b0, 4'h0, 32'h0, "R2 stalled write ignored");
    do_wr(8'h10, 4'h2, mk(8'h10, 4'h2), 1'b1, "R7 draining head no merge");
    do_rd(8'h10, 1'b1, 4'h1, mk(8'h10, 4'h1), "R7 head unchanged");

    line12 = mk(8'h12, 4'h4);
    for (int w = 0; w < 4; w++) begin
      do_wr(8'h12, 4'(1 << w), 32'(8'hA0 + w) << (8 * w), 1'b0, "R3 merge when full");
      line12[w*8 +: 8] = 8'(8'hA0 + w);
    end
    do_rd(8'h12, 1'b1, 4'hF, line12, "R3 merged line");

    // bypass read while writes queued
    rd_req = 1'b1; rd_addr = 8'h55; mem_gnt = 1'b1;
    #1 chk("R5 read first", 32'(mem_req && !mem_we), 1);
    chk("R5 read addr", 32'(mem_addr), 32'h55);
    chk("R5 rd_gnt", 32'(rd_gnt), 1);
    @(negedge clk);
    rd_req = 1'b0; mem_gnt = 1'b0;
    #1 chk("R8 drain resumes same head", 32'(mem_addr), 32'h10);
    chk("R8 drain data kept", mem_data, mk(8'h10, 4'h1));
    @(negedge clk);

    rd_req = 1'b1; rd_addr = 8'h13;
    #1 chk("R6 drain continues on match", 32'(mem_req && mem_we), 1);
    rd_req = 1'b0;
    @(negedge clk);
    do_rd(8'h13, 1'b1, 4'h8, mk(8'h13, 4'h8), "R6 match data");

    do_drain(8'h10, 4'h1, mk(8'h10, 4'h1), "R4 drain 0");
    do_drain(8'h11, 4'h2, mk(8'h11, 4'h2), "R4 drain 1");
    do_drain(8'h12, 4'hF, line12, "R4 drain 2");
    do_drain(8'h13, 4'h8, mk(8'h13, 4'h8), "R4 drain 3");
    #1 chk("R4 empty after drain", 32'(mem_req), 0);
    @(negedge clk);

    // merge attempt on draining head with room: new entry, youngest word wins
    do_wr(8'h30, 4'h1, 32'h0000_0011, 1'b0, "R7 first");
    do_wr(8'h30, 4'h3, 32'h0000_2221, 1'b0, "R7 second");
    do_rd(8'h30, 1'b1, 4'h3, 32'h0000_2221, "R6 youngest wins");
    do_drain(8'h30, 4'h1, 32'h0000_0011, "R7 old entry kept");
    do_drain(8'h30, 4'h3, 32'h0000_2221, "R7 new entry");

    // dirty victim then read miss
    do_wr(8'h40, 4'hF, mk(8'h40, 4'hF), 1'b0, "R9 victim");
    rd_req = 1'b1; rd_addr = 8'h41; mem_gnt = 1'b1;
    #1 chk("R9 read before victim", 32'(mem_addr), 32'h41);
    chk("R9 read op", 32'(mem_we), 0);
    chk("R9 rd_gnt", 32'(rd_gnt), 1);
    @(negedge clk);
    rd_req = 1'b0; mem_gnt = 1'b0;
    do_drain(8'h40, 4'hF, mk(8'h40, 4'hF), "R9 victim after read");
    #1 chk("R9 empty", 32'(mem_req), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule